// File: doc/BRIEF.md
# Prescaled Real-Time Timer with Alarm

This block keeps time from a slow clock. A 16-bit divider produces one roll-over pulse every D slow-clock cycles and, by default, each pulse advances a 32-bit up-counter. When the external-second select is set, the counter is advanced instead by a one-cycle `sec_tick` pulse, which is synchronous to `clk`. The divider keeps running in that mode and still reports its roll-overs.

Three sticky flags are kept in the status register: a roll-over flag, an alarm flag that is set while the count equals a programmed alarm value, and a secondary flag. The secondary flag is set after 4^S roll-overs counted since the last status read, where S is the modulo selection. Reading the status register returns the flags and clears them. The flags drive an alarm output and an interrupt output, each through its own enables.

Software reaches the block through a single-cycle register port. A write to the mode register can restart the divider and clear the counter. A stop bit freezes all counting.

Top module: `rt_timer`

Register map (word address on `addr`):

| addr | Name | Access | Contents |
|------|------|--------|----------|
| 0 | mode | read/write | bits [15:0] divider D; bit 16 alarm-interrupt enable; bit 17 roll-interrupt enable; bit 18 restart (write-only, reads 0); bit 20 stop; bit 21 secondary-to-alarm enable; bit 24 external-second select |
| 1 | alarm | read/write | 32-bit alarm value |
| 2 | modsel | read/write | bits [2:0] modulo selection S |
| 3 | count | read-only | 32-bit count |
| 4 | status | read, clears | bit 0 alarm flag; bit 1 roll flag; bit 2 secondary flag |

## Requirements
- R1: After reset, mode reads 0x00008000, alarm reads 0xFFFFFFFF, modsel, count and status read 0, and `alarm_o` and `irq_o` are low.
- R2: With bit 24 of mode clear, the count (addr 3) advances by one every D clock cycles, where D is mode bits [15:0]. Each roll-over sets status bit 1.
- R3: A divider value of 0, 1 or 2 behaves as a divider of 3.
- R4: With mode bit 24 set, the count advances once per `sec_tick` pulse and is not advanced by roll-overs. Roll-overs still set status bit 1.
- R5: A mode write with bit 18 set clears the count and the divider phase on that same edge, so counting with the newly written D starts from there. Bit 18 reads back as 0.
- R6: While mode bit 20 is set, the count does not change, `sec_tick` is ignored and no roll-over is produced.
- R7: Status bit 0 is set whenever the count equals the alarm register (addr 1).
- R8: A read of status (addr 4 with `rd_en`) returns the flags and clears all three of them. A flag whose event happens in the same cycle as the read stays set.
- R9: Status bit 2 is set on the 4^S-th roll-over since the last status read or restart, where S is modsel bits [2:0]. The window then starts again.
- R10: `alarm_o` is high when status bit 0 is set, or when status bit 2 is set and mode bit 21 is set.
- R11: `irq_o` is high when status bit 0 is set and mode bit 16 is set, or when status bit 1 is set and mode bit 17 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status when addr is 4) |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the strobe cycle |
| sec_tick | input | 1 | External one-second pulse, one cycle wide |
| alarm_o | output | 1 | Alarm output |
| irq_o | output | 1 | Interrupt output |

## Verification
The hardest situations to reach are those where a flag event lands exactly on the edge that consumes a status read. The stimulus restarts the divider and counts edges from that write, so that a read is placed on the precise roll-over edge. A read always restarts the secondary window, so the 4^S-th roll-over cannot be watched through the status register. It is observed instead on `alarm_o` with the secondary-to-alarm enable set, sampled one cycle before and one cycle after the expected edge.

// File: rtl/rt_timer_pkg.sv
package rt_timer_pkg;

    localparam int DIV_W  = 16;
    localparam int CNT_W  = 32;
    localparam int SEL_W  = 3;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int SEC_W  = 2 * ((1 << SEL_W) - 1) + 1;

    localparam logic [DIV_W-1:0] DIV_RESET = 16'h8000;
    localparam int               DIV_MIN   = 3;

    localparam int MB_ALM_IE  = 16;
    localparam int MB_ROLL_IE = 17;
    localparam int MB_RESTART = 18;
    localparam int MB_STOP    = 20;
    localparam int MB_SEC_ALM = 21;
    localparam int MB_EXT     = 24;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE   = 3'd0,
        A_ALARM  = 3'd1,
        A_MODSEL = 3'd2,
        A_COUNT  = 3'd3,
        A_STATUS = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic             ext_sel;
        logic             sec_to_alarm;
        logic             stop;
        logic             roll_ie;
        logic             alm_ie;
        logic [DIV_W-1:0] div;
    } mode_t;

    typedef struct packed {
        logic sec;
        logic roll;
        logic alm;
    } flags_t;

    function automatic mode_t word_to_mode(input logic [DATA_W-1:0] w);
        mode_t m;
        m.div          = w[DIV_W-1:0];
        m.alm_ie       = w[MB_ALM_IE];
        m.roll_ie      = w[MB_ROLL_IE];
        m.stop         = w[MB_STOP];
        m.sec_to_alarm = w[MB_SEC_ALM];
        m.ext_sel      = w[MB_EXT];
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] mode_to_word(input mode_t m);
        logic [DATA_W-1:0] w;
        w                = '0;
        w[DIV_W-1:0]     = m.div;
        w[MB_ALM_IE]     = m.alm_ie;
        w[MB_ROLL_IE]    = m.roll_ie;
        w[MB_STOP]       = m.stop;
        w[MB_SEC_ALM]    = m.sec_to_alarm;
        w[MB_EXT]        = m.ext_sel;
        return w;
    endfunction

endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler
    import rt_timer_pkg::*;
#(
    parameter int W   = DIV_W,
    parameter int MIN = DIV_MIN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         stop,
    input  logic [W-1:0] div,
    output logic         roll
);
    localparam logic [W-1:0] MIN_D = W'(MIN);

    logic [W-1:0] phase_q;
    logic [W-1:0] last;

    // Illegal small dividers fall back to the smallest legal one.
    always_comb begin
        if (div < MIN_D) last = MIN_D - W'(1);
        else             last = div - W'(1);
    end

    assign roll = !stop && (phase_q >= last);

    always_ff @(posedge clk) begin
        if (rst)          phase_q <= '0;
        else if (restart) phase_q <= '0;
        else if (!stop)   phase_q <= roll ? '0 : phase_q + W'(1);
    end

    p_phase_reload_r5: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase_q == '0));

    p_phase_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (stop && !restart) |=> $stable(phase_q));
endmodule

// File: rtl/rt_counter.sv
module rt_counter
    import rt_timer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         stop,
    input  logic         ext_sel,
    input  logic         roll,
    input  logic         sec_tick,
    input  logic [W-1:0] alarm_val,
    output logic [W-1:0] count,
    output logic         match
);
    logic step;

    assign step  = !stop && (ext_sel ? sec_tick : roll);
    assign match = (count == alarm_val);

    always_ff @(posedge clk) begin
        if (rst)          count <= '0;
        else if (restart) count <= '0;
        else if (step)    count <= count + W'(1);
    end

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> ((count == $past(count) + W'(1)) || (count == '0)));

    p_count_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (stop && !restart) |=> $stable(count));

    p_ext_only_r4: assert property (@(posedge clk) disable iff (rst)
        (ext_sel && !sec_tick && !restart) |=> $stable(count));
endmodule

// File: rtl/rt_flags.sv
module rt_flags
    import rt_timer_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int CW = SEC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          rd_status,
    input  logic          roll,
    input  logic          match,
    input  logic [SW-1:0] sel,
    output flags_t        flags
);
    logic [CW-1:0] win_q;
    logic [CW-1:0] limit;
    logic [CW-1:0] base;
    logic [CW-1:0] inc;
    logic          hit;

    // Window length is 4^sel roll-overs.
    assign limit = CW'(1) << (2 * sel);
    assign base  = (rd_status || restart) ? '0 : win_q;
    assign inc   = base + CW'(1);
    assign hit   = roll && (inc == limit);

    always_ff @(posedge clk) begin
        if (rst)       win_q <= '0;
        else if (hit)  win_q <= '0;
        else if (roll) win_q <= inc;
        else           win_q <= base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.alm  <= match | (flags.alm  & !rd_status);
            flags.roll <= roll  | (flags.roll & !rd_status);
            flags.sec  <= hit   | (flags.sec  & !rd_status);
        end
    end

    p_roll_sets_r2: assert property (@(posedge clk) disable iff (rst)
        roll |=> flags.roll);

    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !roll) |=> !flags.roll);

    p_window_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (win_q < limit) || $changed(sel));
endmodule

// File: rtl/rt_timer.sv
module rt_timer
    import rt_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              sec_tick,
    output logic              alarm_o,
    output logic              irq_o
);
    mode_t             mode_q;
    logic [CNT_W-1:0]  alarm_q;
    logic [SEL_W-1:0]  sel_q;
    logic [CNT_W-1:0]  count;
    logic              match;
    logic              roll;
    logic              restart;
    logic              rd_status;
    flags_t            flags;

    assign restart   = wr_en && (addr == A_MODE) && wdata[MB_RESTART];
    assign rd_status = rd_en && (addr == A_STATUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= '0;
            mode_q.div <= DIV_RESET;
            alarm_q    <= '1;
            sel_q      <= '0;
        end else if (wr_en) begin
            case (addr)
                A_MODE:   mode_q  <= word_to_mode(wdata);
                A_ALARM:  alarm_q <= wdata[CNT_W-1:0];
                A_MODSEL: sel_q   <= wdata[SEL_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE:   rdata = mode_to_word(mode_q);
            A_ALARM:  rdata = DATA_W'(alarm_q);
            A_MODSEL: rdata = DATA_W'(sel_q);
            A_COUNT:  rdata = DATA_W'(count);
            A_STATUS: rdata = DATA_W'(flags);
            default:  rdata = '0;
        endcase
    end

    rt_prescaler #(.W(DIV_W), .MIN(DIV_MIN)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .stop    (mode_q.stop),
        .div     (mode_q.div),
        .roll    (roll)
    );

    rt_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .stop      (mode_q.stop),
        .ext_sel   (mode_q.ext_sel),
        .roll      (roll),
        .sec_tick  (sec_tick),
        .alarm_val (alarm_q),
        .count     (count),
        .match     (match)
    );

    rt_flags #(.SW(SEL_W), .CW(SEC_W)) u_flg (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .rd_status (rd_status),
        .roll      (roll),
        .match     (match),
        .sel       (sel_q),
        .flags     (flags)
    );

    assign alarm_o = flags.alm | (mode_q.sec_to_alarm & flags.sec);
    assign irq_o   = (mode_q.alm_ie & flags.alm) | (mode_q.roll_ie & flags.roll);

    p_match_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (count == alarm_q) |=> flags.alm);

    p_alarm_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (!flags.alm && !flags.sec) |-> !alarm_o);

    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.alm_ie && !mode_q.roll_ie) |-> !irq_o);
endmodule

// File: tb/rt_timer_test.sv
module rt_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en, sec_tick;
    logic [2:0]  addr;
    logic [31:0] wdata, rdata;
    logic        alarm_o, irq_o;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rt_timer uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sec_tick(sec_tick),
        .alarm_o(alarm_o), .irq_o(irq_o)
    );

    function automatic logic [31:0] mw(input logic [15:0] d, input bit alm_ie, input bit roll_ie,
                                       input bit rs, input bit stp, input bit sa, input bit ext);
        logic [31:0] w;
        w = {16'h0, d};
        w[16] = alm_ie; w[17] = roll_ie; w[18] = rs;
        w[20] = stp;    w[21] = sa;      w[24] = ext;
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(3'd0, v); chk("R1 mode", v, 32'h0000_8000);
        rd(3'd1, v); chk("R1 alarm", v, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R1 modsel", v, 32'h0);
        rd(3'd3, v); chk("R1 count", v, 32'h0);
        rd(3'd4, v); chk("R1 status", v, 32'h0);
        chk("R1 alarm_o", {31'h0, alarm_o}, 32'h0);
        chk("R1 irq_o", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_prescale;
        logic [31:0] v;
        wr(3'd0, mw(16'd3, 0, 0, 1, 0, 0, 0));
        idle(9);
        rd(3'd3, v); chk("R2 count div3", v, 32'd3);
        rd(3'd0, v); chk("R5 restart reads 0", v, 32'h0000_0003);
        wr(3'd0, mw(16'd5, 0, 0, 1, 0, 0, 0));
        idle(20);
        rd(3'd3, v); chk("R2 count div5", v, 32'd4);
        wr(3'd0, mw(16'd5, 0, 0, 1, 0, 0, 0));
        rd(3'd3, v); chk("R5 restart clears count", v, 32'd0);
    endtask

    task automatic t_illegal;
        logic [31:0] v;
        wr(3'd0, mw(16'd1, 0, 0, 1, 0, 0, 0));
        idle(9);
        rd(3'd3, v); chk("R3 div1 as 3", v, 32'd3);
        wr(3'd0, mw(16'd0, 0, 0, 1, 0, 0, 0));
        idle(12);
        rd(3'd3, v); chk("R3 div0 as 3", v, 32'd4);
    endtask

    task automatic t_same_cycle;
        logic [31:0] v;
        wr(3'd2, 32'd3);
        wr(3'd0, mw(16'd3, 0, 0, 1, 0, 0, 0));
        rd(3'd4, v);
        idle(1);
        rd(3'd4, v); chk("R8 cleared before roll", v & 32'h2, 32'h0);
        rd(3'd4, v); chk("R8 roll on read edge kept", v & 32'h2, 32'h2);
        idle(1);
        rd(3'd4, v); chk("R8 read clears roll", v & 32'h2, 32'h0);
    endtask

    task automatic t_ext;
        logic [31:0] v;
        wr(3'd0, mw(16'd3, 0, 0, 1, 0, 0, 1));
        rd(3'd4, v);
        idle(12);
        rd(3'd3, v); chk("R4 no count from rolls", v, 32'd0);
        rd(3'd4, v); chk("R4 roll flag still set", v & 32'h2, 32'h2);
        repeat (5) begin
            sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0; idle(1);
        end
        rd(3'd3, v); chk("R4 count from ticks", v, 32'd5);
    endtask

    task automatic t_stop;
        logic [31:0] v;
        wr(3'd0, mw(16'd3, 0, 0, 1, 0, 0, 0));
        idle(6);
        wr(3'd0, mw(16'd3, 0, 0, 0, 1, 0, 1));
        rd(3'd4, v);
        idle(12);
        repeat (2) begin
            sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
        end
        rd(3'd3, v); chk("R6 count frozen", v, 32'd2);
        rd(3'd4, v); chk("R6 no roll while stopped", v, 32'h0);
    endtask

    task automatic t_alarm;
        logic [31:0] v;
        wr(3'd1, 32'd4);
        wr(3'd0, mw(16'd3, 1, 0, 1, 0, 0, 0));
        rd(3'd4, v);
        idle(10);
        chk("R7 no alarm before match", {31'h0, alarm_o}, 32'h0);
        chk("R11 no irq before match", {31'h0, irq_o}, 32'h0);
        idle(2);
        chk("R10 alarm_o on match", {31'h0, alarm_o}, 32'h1);
        chk("R11 irq_o alarm enabled", {31'h0, irq_o}, 32'h1);
        idle(5);
        rd(3'd4, v); chk("R7 alarm flag sticky", v & 32'h1, 32'h1);
        rd(3'd4, v); chk("R8 alarm flag cleared", v & 32'h1, 32'h0);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd0, mw(16'd3, 0, 0, 1, 0, 0, 0));
        rd(3'd4, v);
        idle(5);
        chk("R11 roll flag gated off", {31'h0, irq_o}, 32'h0);
        wr(3'd0, mw(16'd3, 0, 1, 0, 0, 0, 0));
        chk("R11 roll flag enabled", {31'h0, irq_o}, 32'h1);
    endtask

    task automatic t_secondary;
        logic [31:0] v;
        wr(3'd2, 32'd1);
        wr(3'd0, mw(16'd3, 0, 0, 1, 0, 1, 0));
        rd(3'd4, v);
        idle(10);
        chk("R9 third roll no secondary", {31'h0, alarm_o}, 32'h0);
        idle(1);
        chk("R9 fourth roll secondary", {31'h0, alarm_o}, 32'h1);
        rd(3'd4, v); chk("R9 status secondary", v, 32'h6);
        wr(3'd0, mw(16'd3, 0, 0, 1, 0, 0, 0));
        rd(3'd4, v);
        idle(12);
        chk("R10 secondary gated off", {31'h0, alarm_o}, 32'h0);
        rd(3'd4, v); chk("R10 secondary flag set", v & 32'h4, 32'h4);
        wr(3'd2, 32'd0);
        wr(3'd0, mw(16'd3, 0, 0, 1, 0, 0, 0));
        rd(3'd4, v);
        idle(3);
        rd(3'd4, v); chk("R9 sel0 every roll", v & 32'h4, 32'h4);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; sec_tick = 1'b0;
        addr = '0; wdata = '0;
        idle(4);
        rst = 1'b0;
        t_reset;
        t_prescale;
        t_illegal;
        t_same_cycle;
        t_ext;
        t_stop;
        t_alarm;
        t_secondary;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule